// File: doc/BRIEF.md
# DMA Request Router Channel with Sync Gating

This block is one output channel of a DMA request router. It picks one peripheral request line out of a parameterised set of up to 128 and hands it to a DMA controller. It can also hold the request back until a trigger arrives on one of up to 32 synchronisation lines, and it can emit a one-cycle event once a programmed number of requests has been forwarded.

A single 32-bit control word configures the channel. It holds the request line, the sync line, the sync edge type, the burst length and three enables. The burst length is the programmed value plus one. In sync mode, a trigger opens the gate for one burst. The gate then closes once the last forwarded request line drops. A trigger that arrives before the current burst has been fully forwarded is an overrun. An overrun sets a sticky flag, and that flag can raise an interrupt.

Top module: `dreq_router`

## Requirements
- R1: After reset the control word reads 0 and `dma_req`, `batch_evt`, `ovr_flag` and `ovr_irq` are low.
- R2: Control word fields: request line [6:0], overrun interrupt enable [8], event enable [9], sync mode enable [16], edge type [18:17], burst value [23:19], sync line [28:24]. All other bits read 0.
- R3: A write leaves the burst field unchanged when the sync mode enable or the event enable is set in the word held before the write. The other fields are still written.
- R4: With sync mode off, `dma_req` equals the selected request line in the same cycle, and lines that are not selected have no effect.
- R5: Each rising edge of the selected line that is forwarded counts toward the burst. When event enable is set, `batch_evt` is high for exactly one cycle, in the cycle after the edge that completes burst value + 1 counted edges. The count then restarts. With event enable clear, no event is produced.
- R6: Edge type encoding: 00 gives no trigger, 01 triggers on a rising edge, 10 on a falling edge, 11 on both. Each edge is judged against the registered previous level of the selected sync line.
- R7: With sync mode on, `dma_req` stays low until a trigger arrives. The trigger cycle itself forwards. After the trigger, burst value + 1 rising edges pass. The gate closes once the line of the last forwarded request falls.
- R8: A trigger while a burst is open and incomplete sets `ovr_flag`. The trigger still restarts the burst. `ovr_clr` clears the flag, and a new set wins over a clear in the same cycle.
- R9: `ovr_irq` is high exactly when `ovr_flag` is high and the overrun interrupt enable is set.
- R10: In a write cycle, edges and triggers are ignored. The write resets the burst count, closes the gate, and takes the edge history from the newly selected lines, so a change of selection creates no false edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 32 | Control word write value |
| csr_rdata | output | 32 | Current control word |
| req_lines | input | N_REQ | Peripheral request lines |
| sync_lines | input | N_SYNC | Synchronisation lines |
| ovr_clr | input | 1 | Clears the overrun flag |
| dma_req | output | 1 | Forwarded request to the DMA controller |
| batch_evt | output | 1 | One-cycle end-of-burst event |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
Directed pulse trains on one request line are run with sync mode off and with sync mode on. They separate plain pass-through counting from gated bursts, and they show whether the event lands after the correct edge. Sync toggles are driven under each edge type, and requests are placed before and after a trigger. These show whether edge decoding and gate closure are right. Back-to-back triggers separate an overrun from a legal restart. Random phases then flip nearby request and sync lines, rewrite the control word with the burst field locked or unlocked, and pulse the clear. Every output is compared each cycle against a bench model, and the noise on lines that are not selected shows whether selection is ignoring them.

// File: rtl/dreq_router_pkg.sv
package dreq_router_pkg;

   localparam int CSR_W        = 32;
   localparam int REQ_SEL_W    = 7;
   localparam int SYNC_SEL_W   = 5;
   localparam int BURST_W      = 5;

   // field positions of the control word
   localparam int POS_REQ_SEL  = 0;
   localparam int POS_OVR_IE   = 8;
   localparam int POS_EVT_EN   = 9;
   localparam int POS_SYNC_EN  = 16;
   localparam int POS_EDGE     = 17;
   localparam int POS_BURST    = 19;
   localparam int POS_SYNC_SEL = 24;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } sync_edge_e;

   typedef enum logic [1:0] {
      GATE_SHUT  = 2'b00,
      GATE_OPEN  = 2'b01,
      GATE_DRAIN = 2'b10
   } gate_e;

   typedef struct packed {
      logic [SYNC_SEL_W-1:0] sync_sel;
      logic [BURST_W-1:0]    burst;
      sync_edge_e            edge_kind;
      logic                  sync_en;
      logic                  evt_en;
      logic                  ovr_ie;
      logic [REQ_SEL_W-1:0]  req_sel;
   } chan_cfg_t;

   function automatic chan_cfg_t csr_decode(input logic [CSR_W-1:0] w);
      chan_cfg_t c;
      c.req_sel   = w[POS_REQ_SEL +: REQ_SEL_W];
      c.ovr_ie    = w[POS_OVR_IE];
      c.evt_en    = w[POS_EVT_EN];
      c.sync_en   = w[POS_SYNC_EN];
      c.edge_kind = sync_edge_e'(w[POS_EDGE +: 2]);
      c.burst     = w[POS_BURST +: BURST_W];
      c.sync_sel  = w[POS_SYNC_SEL +: SYNC_SEL_W];
      return c;
   endfunction

   function automatic logic [CSR_W-1:0] csr_encode(input chan_cfg_t c);
      logic [CSR_W-1:0] w;
      w = '0;
      w[POS_REQ_SEL +: REQ_SEL_W]   = c.req_sel;
      w[POS_OVR_IE]                 = c.ovr_ie;
      w[POS_EVT_EN]                 = c.evt_en;
      w[POS_SYNC_EN]                = c.sync_en;
      w[POS_EDGE +: 2]              = c.edge_kind;
      w[POS_BURST +: BURST_W]       = c.burst;
      w[POS_SYNC_SEL +: SYNC_SEL_W] = c.sync_sel;
      return w;
   endfunction

endpackage

// File: rtl/dreq_router_csr.sv
module dreq_router_csr
   import dreq_router_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CSR_W-1:0] wdata,
   output chan_cfg_t        cfg,
   output logic [CSR_W-1:0] rdata
);

   chan_cfg_t cfg_q, cfg_d, wr_cfg;
   logic      burst_locked;

   always_comb begin
      wr_cfg       = csr_decode(wdata);
      burst_locked = cfg_q.sync_en | cfg_q.evt_en;
      cfg_d        = cfg_q;
      if (wr_en) begin
         cfg_d = wr_cfg;
         if (burst_locked) cfg_d.burst = cfg_q.burst;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_d;
   end

   assign cfg   = cfg_q;
   assign rdata = csr_encode(cfg_q);

   // R3: burst field frozen while either enable is held
   assert_burst_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.sync_en || cfg_q.evt_en) |=> $stable(cfg_q.burst));

endmodule

// File: rtl/dreq_line_pick.sv
module dreq_line_pick #(
   parameter int LINES = 128,
   parameter int SEL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] lines,
   input  logic [SEL_W-1:0] sel,
   input  logic             load,
   input  logic [SEL_W-1:0] load_sel,
   output logic             level,
   output logic             rise,
   output logic             fall
);

   localparam int SPAN = 1 << SEL_W;

   if (LINES > SPAN) begin : g_too_many
      $error("dreq_line_pick: LINES exceeds the select range");
   end
   if (LINES < 1) begin : g_too_few
      $error("dreq_line_pick: LINES must be at least 1");
   end

   logic [SPAN-1:0] padded;
   logic            hist_q;

   if (LINES == SPAN) begin : g_full
      assign padded = lines;
   end else begin : g_part
      assign padded = {{(SPAN-LINES){1'b0}}, lines};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    hist_q <= 1'b0;
      else if (load) hist_q <= padded[load_sel];
      else           hist_q <= padded[sel];
   end

   assign level = padded[sel];
   assign rise  = level & ~hist_q;
   assign fall  = ~level & hist_q;

endmodule

// File: rtl/dreq_batch.sv
module dreq_batch
   import dreq_router_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               sync_en,
   input  logic               evt_en,
   input  logic [BURST_W-1:0] burst,
   input  logic               rise,
   input  logic               level,
   input  logic               sync_hit,
   input  logic               ovr_clr,
   output logic               pass,
   output logic               evt,
   output logic               ovr
);

   gate_e              gate_q, gate_d;
   logic [BURST_W-1:0] done_q, done_d, base;
   logic               evt_d, ovr_set, window, last;

   always_comb begin
      window  = !sync_en || (gate_q != GATE_SHUT) || (sync_hit && !load);
      base    = (sync_en && sync_hit) ? '0 : done_q;
      last    = (base == burst);
      gate_d  = gate_q;
      done_d  = done_q;
      evt_d   = 1'b0;
      ovr_set = 1'b0;
      if (load) begin
         gate_d = GATE_SHUT;
         done_d = '0;
      end else if (!sync_en) begin
         gate_d = GATE_SHUT;
         if (rise) begin
            if (last) begin
               evt_d  = evt_en;
               done_d = '0;
            end else begin
               done_d = done_q + 1'b1;
            end
         end
      end else begin
         ovr_set = sync_hit && (gate_q == GATE_OPEN);
         if (rise && window) begin
            if (last) begin
               evt_d  = evt_en;
               done_d = '0;
               gate_d = GATE_DRAIN;
            end else begin
               done_d = base + 1'b1;
               gate_d = GATE_OPEN;
            end
         end else if (sync_hit) begin
            gate_d = GATE_OPEN;
            done_d = '0;
         end else if (gate_q == GATE_DRAIN && !level) begin
            gate_d = GATE_SHUT;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q <= GATE_SHUT;
         done_q <= '0;
         evt    <= 1'b0;
         ovr    <= 1'b0;
      end else begin
         gate_q <= gate_d;
         done_q <= done_d;
         evt    <= evt_d;
         ovr    <= ovr_set | (ovr & ~ovr_clr);
      end
   end

   assign pass = window;

   // R5: event only when enabled, never two cycles running
   assert_evt_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> $past(evt_en));
   assert_evt_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);
   // R7: the running count never passes the burst value in sync mode
   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_en |-> (done_q <= burst));
   // R8: overrun only arises in sync mode
   assert_ovr_sync_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(sync_en));

endmodule

// File: rtl/dreq_router.sv
module dreq_router
   import dreq_router_pkg::*;
#(
   parameter int N_REQ  = 128,
   parameter int N_SYNC = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [CSR_W-1:0]  csr_wdata,
   output logic [CSR_W-1:0]  csr_rdata,
   input  logic [N_REQ-1:0]  req_lines,
   input  logic [N_SYNC-1:0] sync_lines,
   input  logic              ovr_clr,
   output logic              dma_req,
   output logic              batch_evt,
   output logic              ovr_flag,
   output logic              ovr_irq
);

   chan_cfg_t cfg;
   logic      req_level, req_rise, req_fall;
   logic      sync_level, sync_rise, sync_fall;
   logic      sync_hit, gate_pass;

   dreq_router_csr u_csr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (csr_wr),
      .wdata (csr_wdata),
      .cfg   (cfg),
      .rdata (csr_rdata)
   );

   dreq_line_pick #(.LINES(N_REQ), .SEL_W(REQ_SEL_W)) u_req_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines    (req_lines),
      .sel      (cfg.req_sel),
      .load     (csr_wr),
      .load_sel (csr_wdata[POS_REQ_SEL +: REQ_SEL_W]),
      .level    (req_level),
      .rise     (req_rise),
      .fall     (req_fall)
   );

   dreq_line_pick #(.LINES(N_SYNC), .SEL_W(SYNC_SEL_W)) u_sync_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines    (sync_lines),
      .sel      (cfg.sync_sel),
      .load     (csr_wr),
      .load_sel (csr_wdata[POS_SYNC_SEL +: SYNC_SEL_W]),
      .level    (sync_level),
      .rise     (sync_rise),
      .fall     (sync_fall)
   );

   always_comb begin
      unique case (cfg.edge_kind)
         EDGE_OFF:  sync_hit = 1'b0;
         EDGE_RISE: sync_hit = sync_rise;
         EDGE_FALL: sync_hit = sync_fall;
         EDGE_ANY:  sync_hit = sync_rise | sync_fall;
         default:   sync_hit = 1'b0;
      endcase
      sync_hit = sync_hit & cfg.sync_en;
   end

   dreq_batch u_batch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (csr_wr),
      .sync_en  (cfg.sync_en),
      .evt_en   (cfg.evt_en),
      .burst    (cfg.burst),
      .rise     (req_rise),
      .level    (req_level),
      .sync_hit (sync_hit),
      .ovr_clr  (ovr_clr),
      .pass     (gate_pass),
      .evt      (batch_evt),
      .ovr      (ovr_flag)
   );

   assign dma_req = req_level & gate_pass;
   assign ovr_irq = ovr_flag & cfg.ovr_ie;

   // R4: plain pass-through when sync mode is off
   assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.sync_en |-> (dma_req == req_level));
   // R5: a falling request edge is never followed by an event
   assert_fall_no_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_fall |=> !batch_evt);
   // R6: a level that did not move triggers nothing
   assert_no_edge_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_rise && !sync_fall) |-> !sync_hit);
   // R9: interrupt rises only with its enable
   assert_irq_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_irq) |-> cfg.ovr_ie);
   // R6: observed sync level is the selected line
   assert_sync_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_level == sync_lines[cfg.sync_sel]);

endmodule

// File: tb/sim_dreq_router.sv
`timescale 1ns/1ps
module sim_dreq_router;

   localparam int NR = 128;
   localparam int NS = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          csr_wr = 1'b0;
   logic [31:0]   csr_wdata = '0;
   logic [31:0]   csr_rdata;
   logic [NR-1:0] req_lines = '0;
   logic [NS-1:0] sync_lines = '0;
   logic          ovr_clr = 1'b0;
   logic          dma_req, batch_evt, ovr_flag, ovr_irq;

   always #5 clk = ~clk;

   dreq_router #(.N_REQ(NR), .N_SYNC(NS)) u0 (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .req_lines(req_lines), .sync_lines(sync_lines),
      .ovr_clr(ovr_clr), .dma_req(dma_req), .batch_evt(batch_evt),
      .ovr_flag(ovr_flag), .ovr_irq(ovr_irq));

   int checks = 0;
   int failures = 0;
   bit done = 0;
   int fwd_edges = 0;
   int evt_seen = 0;
   logic prev_dma = 1'b0;

   // bench model
   logic [6:0] m_sel;  logic m_ie, m_ee, m_se;  logic [1:0] m_pol;
   logic [4:0] m_cnt;  logic [4:0] m_sid;
   int         m_gate;  logic [4:0] m_done;
   logic       m_evt, m_ovr, m_rh, m_sh;

   task automatic model_reset();
      m_sel = '0; m_ie = 0; m_ee = 0; m_se = 0; m_pol = '0; m_cnt = '0; m_sid = '0;
      m_gate = 0; m_done = '0; m_evt = 0; m_ovr = 0; m_rh = 0; m_sh = 0;
   endtask

   function automatic logic m_hit();
      logic l, r, f;
      l = sync_lines[m_sid];
      r = l & ~m_sh;
      f = ~l & m_sh;
      case (m_pol)
         2'b01:   return m_se & r;
         2'b10:   return m_se & f;
         2'b11:   return m_se & (r | f);
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic m_pass();
      return !m_se || (m_gate != 0) || (m_hit() && !csr_wr);
   endfunction

   function automatic logic [31:0] m_word();
      return {3'b000, m_sid, m_cnt, m_pol, m_se, 6'b0, m_ee, m_ie, 1'b0, m_sel};
   endfunction

   task automatic model_step();
      logic lvl, rise, sh, win, last;
      logic [4:0] base;
      logic nevt, nset;
      lvl = req_lines[m_sel];
      rise = lvl & ~m_rh;
      sh = m_hit();
      win = m_pass();
      nevt = 0; nset = 0;
      if (csr_wr) begin
         if (!(m_se || m_ee)) m_cnt = csr_wdata[23:19];
         m_sel = csr_wdata[6:0];  m_ie = csr_wdata[8];  m_ee = csr_wdata[9];
         m_se = csr_wdata[16];    m_pol = csr_wdata[18:17]; m_sid = csr_wdata[28:24];
         m_gate = 0; m_done = '0;
         m_rh = req_lines[m_sel]; m_sh = sync_lines[m_sid];
      end else begin
         base = (m_se && sh) ? 5'd0 : m_done;
         last = (base == m_cnt);
         if (!m_se) begin
            m_gate = 0;
            if (rise) begin
               if (last) begin nevt = m_ee; m_done = '0; end
               else m_done = m_done + 5'd1;
            end
         end else begin
            nset = sh && (m_gate == 1);
            if (rise && win) begin
               if (last) begin nevt = m_ee; m_done = '0; m_gate = 2; end
               else begin m_done = base + 5'd1; m_gate = 1; end
            end else if (sh) begin
               m_gate = 1; m_done = '0;
            end else if (m_gate == 2 && !lvl) begin
               m_gate = 0;
            end
         end
         m_rh = lvl; m_sh = sync_lines[m_sid];
      end
      m_evt = nevt;
      m_ovr = nset | (m_ovr & ~ovr_clr);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(m_se ? "R7 dma_req gated" : "R4 dma_req", 32'(dma_req), 32'(req_lines[m_sel] & m_pass()));
      chk("R5 batch_evt", 32'(batch_evt), 32'(m_evt));
      chk("R8 ovr_flag", 32'(ovr_flag), 32'(m_ovr));
      chk("R9 ovr_irq", 32'(ovr_irq), 32'(m_ovr & m_ie));
      chk("R2 csr_rdata", csr_rdata, m_word());
   endtask

   task automatic step(input logic wr, input logic [31:0] wd, input logic clr);
      @(negedge clk);
      csr_wr = wr; csr_wdata = wd; ovr_clr = clr;
      #1;
      compare_all();
      if (dma_req && !prev_dma) fwd_edges++;
      prev_dma = dma_req;
      if (batch_evt) evt_seen++;
      @(posedge clk);
      #1;
      model_step();
      csr_wr = 1'b0; ovr_clr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b0, 32'h0, 1'b0);
   endtask

   task automatic pulse_req(input int line);
      req_lines[line] = 1'b1; idle(2);
      req_lines[line] = 1'b0; idle(2);
   endtask

   function automatic logic [31:0] word(input int sel, input bit ie, input bit ee,
                                        input bit se, input int pol, input int cnt, input int sid);
      logic [31:0] w;
      w = '0;
      w[6:0] = 7'(sel); w[8] = ie; w[9] = ee; w[16] = se;
      w[18:17] = 2'(pol); w[23:19] = 5'(cnt); w[28:24] = 5'(sid);
      return w;
   endfunction

   initial begin
      #1500000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int e0, f0;
      r = $urandom(32'd1234);
      model_reset();
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1: reset state
      @(negedge clk);
      chk("R1 rdata after reset", csr_rdata, 32'h0);
      chk("R1 outputs after reset", {28'h0, dma_req, batch_evt, ovr_flag, ovr_irq}, 32'h0);

      // R2: every field writable, gaps read zero
      step(1'b1, 32'hFFFF_FFFF, 1'b0);
      @(negedge clk);
      chk("R2 field mask readback", csr_rdata, 32'h1FFF_037F);
      // R3: burst locked while enables are set
      step(1'b1, word(3, 0, 1, 1, 1, 4, 2), 1'b0);
      @(negedge clk);
      chk("R3 burst kept under lock", 32'(csr_rdata[23:19]), 32'd31);
      step(1'b1, 32'h0, 1'b0);
      step(1'b1, word(5, 0, 1, 0, 0, 2, 0), 1'b0);
      @(negedge clk);
      chk("R3 burst written when unlocked", 32'(csr_rdata[23:19]), 32'd2);

      // R5: non-sync counting, burst of three, noise on other lines
      e0 = evt_seen;
      for (int p = 0; p < 6; p++) begin
         req_lines[6] = ~req_lines[6];
         pulse_req(5);
      end
      idle(2);
      chk("R5 two events for six edges", 32'(evt_seen - e0), 32'd2);
      req_lines = '0;

      // R7: sync mode, rising trigger, burst of two
      step(1'b1, 32'h0, 1'b0);
      step(1'b1, word(5, 1, 1, 0, 0, 1, 3), 1'b0);
      step(1'b1, word(5, 1, 1, 1, 1, 0, 3), 1'b0);
      f0 = fwd_edges;
      pulse_req(5);
      chk("R7 blocked before trigger", 32'(fwd_edges - f0), 32'd0);
      sync_lines[3] = 1'b1; idle(1);
      for (int p = 0; p < 3; p++) pulse_req(5);
      chk("R7 exactly two forwarded", 32'(fwd_edges - f0), 32'd2);

      // R8/R9: trigger twice inside one burst
      sync_lines[3] = 1'b0; idle(1);
      sync_lines[3] = 1'b1; idle(1);
      pulse_req(5);
      sync_lines[3] = 1'b0; idle(1);
      sync_lines[3] = 1'b1; idle(2);
      chk("R8 overrun flagged", 32'(ovr_flag), 32'd1);
      chk("R9 irq with enable", 32'(ovr_irq), 32'd1);
      step(1'b0, 32'h0, 1'b1);
      @(negedge clk);
      chk("R8 overrun cleared", 32'(ovr_flag), 32'd0);

      // R6: edge type off, toggling sync opens nothing
      step(1'b1, word(5, 0, 1, 1, 0, 0, 3), 1'b0);
      f0 = fwd_edges;
      for (int p = 0; p < 3; p++) begin
         sync_lines[3] = ~sync_lines[3]; idle(1);
         pulse_req(5);
      end
      chk("R6 no trigger with edge type off", 32'(fwd_edges - f0), 32'd0);

      // R6: falling edge type
      step(1'b1, word(5, 0, 1, 1, 2, 0, 3), 1'b0);
      sync_lines[3] = 1'b1; idle(1);
      f0 = fwd_edges;
      pulse_req(5);
      chk("R6 rising ignored under falling type", 32'(fwd_edges - f0), 32'd0);
      sync_lines[3] = 1'b0; idle(1);
      pulse_req(5);
      chk("R6 falling edge opens gate", 32'(fwd_edges - f0), 32'd1);

      // R10: edge in write cycle ignored, selection change makes no false edge
      req_lines[9] = 1'b1;
      sync_lines[4] = 1'b1;
      step(1'b1, word(9, 0, 1, 1, 1, 0, 4), 1'b0);
      idle(3);
      chk("R10 no trigger from new selection", 32'(dma_req), 32'd0);
      req_lines[9] = 1'b0; sync_lines = '0; idle(2);

      // random phase
      for (int i = 0; i < 6000; i++) begin
         logic clr;
         if (i % 250 == 0) begin
            if (($urandom % 2) == 0) step(1'b1, 32'h0, 1'b0);
            r = word($urandom % 8, $urandom % 2, $urandom % 2, $urandom % 2,
                     $urandom % 4, (($urandom % 4) == 0) ? ($urandom % 32) : ($urandom % 4),
                     $urandom % 4);
            step(1'b1, r, 1'b0);
         end else begin
            if (($urandom % 2) == 0) req_lines[$urandom % 8] ^= 1'b1;
            if (($urandom % 8) == 0) sync_lines[$urandom % 4] ^= 1'b1;
            clr = (($urandom % 16) == 0);
            step(1'b0, 32'h0, clr);
         end
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule